// File: doc/BRIEF.md
# Segmented Address Translator with Access Permissions

This block turns a program address into a physical address through a small table of segment descriptors. The top bits of the incoming address pick one descriptor, and the remaining bits are an offset. Each descriptor holds a base, a bound and three permission bits (read, write, execute), plus a valid flag. The offset must fall below the bound, and the kind of access (load, store or instruction fetch) must be allowed by the permission bits. A request that passes both checks comes out as base plus offset. Any other request comes out as a fault with a two-bit cause and the offending address.

Descriptors are loaded through a configuration port. A write is honoured only while the privilege qualifier is high. A typical process owns one execute-only or execute-read code segment and its own read-write data segment with execute clear. Several processes can point their code descriptors at the same physical code while keeping separate data segments. Because data and stack segments have execute clear, fetching from them faults.

The descriptor table is a synchronous-read memory. A request therefore takes two clock edges: one to read the descriptor and one to register the result. Results stay on the outputs until the next response replaces them.

Top module: `seg_xlate`

## Requirements
- R1: The top 4 address bits select one of 16 descriptors and the low 28 bits are the offset. A passing request returns rsp_paddr = base + offset (modulo 2^32) with rsp_cause = 0 (none).
- R2: rsp_valid pulses high for one cycle, exactly two rising edges after the edge that samples req_valid high. While rsp_valid is low, rsp_cause, rsp_paddr and rsp_fault_addr hold the values of the last response.
- R3: After reset every descriptor is absent. A request to a descriptor whose valid flag is clear returns cause 1 (not-present). Writing a descriptor with cfg_valid = 0 makes it absent.
- R4: An offset greater than or equal to the descriptor's bound returns cause 2 (bound). An offset equal to bound - 1 passes.
- R5: Each access type needs one permission bit. req_type 0 (load) needs cfg_perm bit 0 (read), 1 (store) needs bit 1 (write), and 2 (fetch) needs bit 2 (execute). req_type 3 is never granted. A missing permission returns cause 3 (permission). A fetch from a segment with execute clear therefore faults even when read and write are set.
- R6: Causes are checked in a fixed order: not-present before bound, and bound before permission.
- R7: On a fault, rsp_paddr is 0 and rsp_fault_addr is the request address. On success, rsp_fault_addr is 0.
- R8: A descriptor is written only on a cycle where cfg_we and cfg_priv are both high. A write with cfg_priv low leaves the table unchanged.
- R9: A descriptor write acts on requests sampled at later edges. A request sampled at the same edge as the write sees the old descriptor.
- R10: While rst is high, and after reset, rsp_valid, rsp_cause, rsp_paddr and rsp_fault_addr are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_priv | input | 1 | Privilege qualifier; the write is honoured only when high |
| cfg_idx | input | 4 | Descriptor index to write |
| cfg_valid | input | 1 | Valid flag written to the descriptor |
| cfg_perm | input | 3 | Permissions: bit 0 read, bit 1 write, bit 2 execute |
| cfg_base | input | 32 | Physical base of the segment |
| cfg_bound | input | 28 | Segment length; an offset must be below this value |
| req_valid | input | 1 | Translation request strobe |
| req_type | input | 2 | 0 load, 1 store, 2 fetch, 3 never granted |
| req_addr | input | 32 | Address to translate |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_cause | output | 2 | 0 none, 1 not-present, 2 bound, 3 permission |
| rsp_paddr | output | 32 | Physical address, 0 on a fault |
| rsp_fault_addr | output | 32 | Faulting address, 0 on success |

## Verification
Directed requests cover each cause on its own. They include loads, stores and fetches that pass; an offset at bound - 1 and at bound; a fetch from a read-write segment; a store to a code segment; the never-granted access type; and an absent descriptor. These separate the four causes and show the bound comparison is strict. Paired faults show the priority order, and a descriptor whose base plus offset overflows shows that the sum wraps. Further cases pair an unprivileged write with a later request, and a write with a request at the same edge. Others issue back-to-back requests and idle gaps, which separate held outputs from fresh ones. Randomised traffic then mixes writes, privileged and not, with requests that land near the bounds, all compared against a behavioural model on every clock.

// File: rtl/seg_pkg.sv
package seg_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_ABSENT = 2'd1,
    CAUSE_BOUND  = 2'd2,
    CAUSE_PERM   = 2'd3
  } cause_e;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  localparam int NUM_PERM = 3;
endpackage

// File: rtl/seg_desc_ram.sv
module seg_desc_ram #(
  parameter int SEL_W   = 4,
  parameter int ENTRY_W = 63
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [SEL_W-1:0]   wr_idx,
  input  logic [ENTRY_W-1:0] wr_entry,
  input  logic               wr_present,
  input  logic [SEL_W-1:0]   rd_idx,
  output logic [ENTRY_W-1:0] rd_entry,
  output logic               rd_present
);
  localparam int DEPTH = 1 << SEL_W;

  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]   present_q;

  // Descriptor payload: plain synchronous RAM, read-before-write.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_entry;
    rd_entry <= mem[rd_idx];
  end

  // Valid flags live in flops so reset can clear them.
  always_ff @(posedge clk) begin
    if (rst) begin
      present_q  <= '0;
      rd_present <= 1'b0;
    end else begin
      if (wr_en) present_q[wr_idx] <= wr_present;
      rd_present <= present_q[rd_idx];
    end
  end
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_pkg::*;
#(
  parameter int OFF_W = 28,
  parameter int PA_W  = 32
) (
  input  logic                present,
  input  logic [PA_W-1:0]     base,
  input  logic [OFF_W-1:0]    bound,
  input  logic [NUM_PERM-1:0] perm,
  input  logic [OFF_W-1:0]    offset,
  input  logic [1:0]          acc,
  output cause_e              cause,
  output logic [PA_W-1:0]     paddr
);
  logic [NUM_PERM-1:0] grant;
  logic                allowed;
  logic                over;

  // One grant term per access type; an unlisted type matches no term.
  for (genvar a = 0; a < NUM_PERM; a++) begin : g_grant
    assign grant[a] = (acc == 2'(a)) && perm[a];
  end
  assign allowed = |grant;
  assign over    = (offset >= bound);
  assign paddr   = base + PA_W'(offset);

  always_comb begin
    if (!present)      cause = CAUSE_ABSENT;
    else if (over)     cause = CAUSE_BOUND;
    else if (!allowed) cause = CAUSE_PERM;
    else               cause = CAUSE_NONE;
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_pkg::*;
#(
  parameter int  ADDR_W = 32,
  parameter int  SEL_W  = 4,
  parameter int  PA_W   = 32,
  localparam int OFF_W  = ADDR_W - SEL_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic                cfg_priv,
  input  logic [SEL_W-1:0]    cfg_idx,
  input  logic                cfg_valid,
  input  logic [2:0]          cfg_perm,
  input  logic [PA_W-1:0]     cfg_base,
  input  logic [OFF_W-1:0]    cfg_bound,
  input  logic                req_valid,
  input  logic [1:0]          req_type,
  input  logic [ADDR_W-1:0]   req_addr,
  output logic                rsp_valid,
  output logic [1:0]          rsp_cause,
  output logic [PA_W-1:0]     rsp_paddr,
  output logic [ADDR_W-1:0]   rsp_fault_addr
);
  localparam int ENTRY_W = NUM_PERM + OFF_W + PA_W;

  logic               wr_ok;
  logic [ENTRY_W-1:0] rd_entry;
  logic               rd_present;

  logic               s1_v;
  logic [ADDR_W-1:0]  s1_addr;
  logic [1:0]         s1_type;

  cause_e             chk_cause;
  logic [PA_W-1:0]    chk_paddr;

  assign wr_ok = cfg_we & cfg_priv;

  seg_desc_ram #(.SEL_W(SEL_W), .ENTRY_W(ENTRY_W)) u_table (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_ok),
    .wr_idx     (cfg_idx),
    .wr_entry   ({cfg_perm, cfg_bound, cfg_base}),
    .wr_present (cfg_valid),
    .rd_idx     (req_addr[ADDR_W-1 -: SEL_W]),
    .rd_entry   (rd_entry),
    .rd_present (rd_present)
  );

  // Stage 1: carry the request alongside the descriptor read.
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v    <= 1'b0;
      s1_addr <= '0;
      s1_type <= '0;
    end else begin
      s1_v    <= req_valid;
      s1_addr <= req_addr;
      s1_type <= req_type;
    end
  end

  seg_check #(.OFF_W(OFF_W), .PA_W(PA_W)) u_check (
    .present (rd_present),
    .base    (rd_entry[PA_W-1:0]),
    .bound   (rd_entry[PA_W +: OFF_W]),
    .perm    (rd_entry[PA_W+OFF_W +: NUM_PERM]),
    .offset  (s1_addr[OFF_W-1:0]),
    .acc     (s1_type),
    .cause   (chk_cause),
    .paddr   (chk_paddr)
  );

  // Stage 2: registered result, held until the next response.
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid      <= 1'b0;
      rsp_cause      <= CAUSE_NONE;
      rsp_paddr      <= '0;
      rsp_fault_addr <= '0;
    end else begin
      rsp_valid <= s1_v;
      if (s1_v) begin
        rsp_cause <= chk_cause;
        if (chk_cause == CAUSE_NONE) begin
          rsp_paddr      <= chk_paddr;
          rsp_fault_addr <= '0;
        end else begin
          rsp_paddr      <= '0;
          rsp_fault_addr <= s1_addr;
        end
      end
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int ADDR_W = 32,
  parameter int PA_W   = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              rsp_valid,
  input logic [1:0]        rsp_cause,
  input logic [PA_W-1:0]   rsp_paddr,
  input logic [ADDR_W-1:0] rsp_fault_addr
);
  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid, 2));

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> ($stable(rsp_cause) && $stable(rsp_paddr) && $stable(rsp_fault_addr)));

  assert_fault_paddr_R7: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_cause != 2'd0) |-> (rsp_paddr == '0));

  assert_ok_faddr_R7: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_cause == 2'd0) |-> (rsp_fault_addr == '0));

  assert_reset_R10: assert property (@(posedge clk)
    rst |=> (!rsp_valid && rsp_cause == 2'd0 && rsp_paddr == '0 && rsp_fault_addr == '0));
endmodule

bind seg_xlate seg_xlate_chk #(.ADDR_W(ADDR_W), .PA_W(PA_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .req_valid      (req_valid),
  .rsp_valid      (rsp_valid),
  .rsp_cause      (rsp_cause),
  .rsp_paddr      (rsp_paddr),
  .rsp_fault_addr (rsp_fault_addr)
);

// File: tb/seg_xlate_tb.sv
`timescale 1ns/1ps
module seg_xlate_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 0, cfg_priv = 0, cfg_valid = 0;
  logic [3:0]  cfg_idx = 0;
  logic [2:0]  cfg_perm = 0;
  logic [31:0] cfg_base = 0;
  logic [27:0] cfg_bound = 0;
  logic        req_valid = 0;
  logic [1:0]  req_type = 0;
  logic [31:0] req_addr = 0;
  logic        rsp_valid;
  logic [1:0]  rsp_cause;
  logic [31:0] rsp_paddr, rsp_fault_addr;

  int checks = 0, fails = 0;
  bit started = 0;

  always #2 clk = ~clk;

  seg_xlate u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_priv(cfg_priv), .cfg_idx(cfg_idx),
    .cfg_valid(cfg_valid), .cfg_perm(cfg_perm), .cfg_base(cfg_base), .cfg_bound(cfg_bound),
    .req_valid(req_valid), .req_type(req_type), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_cause(rsp_cause), .rsp_paddr(rsp_paddr),
    .rsp_fault_addr(rsp_fault_addr)
  );

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_base [16];
  logic [27:0] m_bound[16];
  logic [2:0]  m_perm [16];
  bit          m_ok   [16];
  bit          p_v, m_v;
  int          p_cause, m_cause;
  logic [31:0] p_pa, p_fa, m_pa, m_fa;

  function automatic int eval_cause(input logic [31:0] a, input logic [1:0] t);
    int s = int'(a[31:28]);
    if (!m_ok[s]) return 1;
    if (a[27:0] >= m_bound[s]) return 2;
    if (t == 2'd3 || !m_perm[s][t]) return 3;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 16; i++) m_ok[i] = 0;
      p_v = 0; m_v = 0; m_cause = 0; m_pa = 0; m_fa = 0;
    end else begin
      m_v = p_v;
      if (p_v) begin m_cause = p_cause; m_pa = p_pa; m_fa = p_fa; end
      p_v = req_valid;
      if (req_valid) begin
        p_cause = eval_cause(req_addr, req_type);
        if (p_cause == 0) begin
          p_pa = m_base[req_addr[31:28]] + {4'h0, req_addr[27:0]};
          p_fa = 0;
        end else begin
          p_pa = 0; p_fa = req_addr;
        end
      end
      if (cfg_we && cfg_priv) begin
        m_base[cfg_idx] = cfg_base; m_bound[cfg_idx] = cfg_bound;
        m_perm[cfg_idx] = cfg_perm; m_ok[cfg_idx] = cfg_valid;
      end
    end
  end

  function automatic string cause_tag(input int c);
    case (c)
      0: return "R1";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  always @(negedge clk) begin
    if (started) begin
      checks++;
      if (rsp_valid !== m_v) begin
        fails++; $display("FAIL R2 model rsp_valid act=%0b exp=%0b", rsp_valid, m_v);
      end
      checks++;
      if (rsp_cause !== 2'(m_cause)) begin
        fails++; $display("FAIL %s model cause act=%0d exp=%0d", cause_tag(m_cause), rsp_cause, m_cause);
      end
      checks++;
      if (rsp_paddr !== m_pa) begin
        fails++; $display("FAIL R1 model paddr act=%h exp=%h", rsp_paddr, m_pa);
      end
      checks++;
      if (rsp_fault_addr !== m_fa) begin
        fails++; $display("FAIL R7 model fault_addr act=%h exp=%h", rsp_fault_addr, m_fa);
      end
    end
  end

  // ---------------- directed helpers ----------------
  task automatic wr_desc(input logic [3:0] idx, input logic [31:0] b, input logic [27:0] bd,
                         input logic [2:0] pm, input bit vld, input bit priv);
    @(negedge clk);
    cfg_we = 1; cfg_priv = priv; cfg_idx = idx; cfg_base = b; cfg_bound = bd;
    cfg_perm = pm; cfg_valid = vld;
    @(negedge clk);
    cfg_we = 0; cfg_priv = 0;
  endtask

  task automatic check_out(input string tag, input logic [1:0] ec,
                           input logic [31:0] epa, input logic [31:0] efa);
    checks++;
    if (rsp_valid !== 1'b1 || rsp_cause !== ec || rsp_paddr !== epa || rsp_fault_addr !== efa) begin
      fails++;
      $display("FAIL %s act v=%0b c=%0d pa=%h fa=%h exp v=1 c=%0d pa=%h fa=%h",
               tag, rsp_valid, rsp_cause, rsp_paddr, rsp_fault_addr, ec, epa, efa);
    end
  endtask

  task automatic xlate(input string tag, input logic [31:0] a, input logic [1:0] t,
                       input logic [1:0] ec, input logic [31:0] epa);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_type = t;
    @(negedge clk);
    req_valid = 0;
    @(negedge clk);
    check_out(tag, ec, epa, (ec == 2'd0) ? 32'h0 : a);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    repeat (4) @(negedge clk);
    // R10: outputs cleared while in reset
    checks++;
    if (rsp_valid !== 0 || rsp_cause !== 0 || rsp_paddr !== 0 || rsp_fault_addr !== 0) begin
      fails++; $display("FAIL R10 reset act v=%0b c=%0d pa=%h fa=%h exp all 0",
                        rsp_valid, rsp_cause, rsp_paddr, rsp_fault_addr);
    end
    rst = 0;
    started = 1;

    // R3: all descriptors absent after reset
    xlate("R3 absent after reset", 32'h0000_0010, 2'd0, 2'd1, 32'h0);

    wr_desc(4'd0,  32'h1000_0000, 28'h010_0000, 3'b101, 1, 1); // code: exec+read
    wr_desc(4'd1,  32'h2000_0000, 28'h000_8000, 3'b011, 1, 1); // data A
    wr_desc(4'd2,  32'h3000_0000, 28'h000_8000, 3'b011, 1, 1); // data B
    wr_desc(4'd15, 32'hFFFF_F000, 28'h000_2000, 3'b111, 1, 1);

    xlate("R1 fetch code",           32'h0000_0040, 2'd2, 2'd0, 32'h1000_0040);
    xlate("R4 offset bound-1 ok",    32'h1000_7FFF, 2'd0, 2'd0, 32'h2000_7FFF);
    xlate("R4 offset at bound",      32'h1000_8000, 2'd1, 2'd2, 32'h0);
    xlate("R5 fetch from data",      32'h1000_0010, 2'd2, 2'd3, 32'h0);
    xlate("R5 store to code",        32'h0000_0010, 2'd1, 2'd3, 32'h0);
    xlate("R1 second data seg",      32'h2000_0010, 2'd1, 2'd0, 32'h3000_0010);
    xlate("R5 type 3 never granted", 32'h1000_0000, 2'd3, 2'd3, 32'h0);
    xlate("R3 absent seg 5",         32'h5000_0000, 2'd0, 2'd1, 32'h0);
    xlate("R6 bound over perm",      32'h1000_9000, 2'd2, 2'd2, 32'h0);
    xlate("R6 absent over bound",    32'h7FFF_FFFF, 2'd3, 2'd1, 32'h0);
    xlate("R1 base+offset wraps",    32'hF000_1800, 2'd0, 2'd0, 32'h0000_0800);

    // R2: outputs held through idle cycles
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid !== 0 || rsp_cause !== 0 || rsp_paddr !== 32'h0000_0800) begin
      fails++; $display("FAIL R2 hold act v=%0b c=%0d pa=%h exp v=0 c=0 pa=00000800",
                        rsp_valid, rsp_cause, rsp_paddr);
    end

    // R8: unprivileged write ignored
    wr_desc(4'd3, 32'h4000_0000, 28'h100, 3'b111, 1, 0);
    xlate("R8 unprivileged write ignored", 32'h3000_0000, 2'd0, 2'd1, 32'h0);

    // R9: write and request at the same edge -> old descriptor
    @(negedge clk);
    cfg_we = 1; cfg_priv = 1; cfg_idx = 4'd4; cfg_base = 32'h4000_0000;
    cfg_bound = 28'h100; cfg_perm = 3'b001; cfg_valid = 1;
    req_valid = 1; req_addr = 32'h4000_0004; req_type = 2'd0;
    @(negedge clk);
    cfg_we = 0; cfg_priv = 0; req_valid = 0;
    @(negedge clk);
    check_out("R9 same-edge sees old", 2'd1, 32'h0, 32'h4000_0004);
    xlate("R9 later request sees new", 32'h4000_0004, 2'd0, 2'd0, 32'h4000_0004);

    // R2: back-to-back responses
    @(negedge clk);
    req_valid = 1; req_addr = 32'h0000_0100; req_type = 2'd0;
    @(negedge clk);
    req_addr = 32'h1000_0200; req_type = 2'd1;
    @(negedge clk);
    req_valid = 0;
    check_out("R2 back-to-back first", 2'd0, 32'h1000_0100, 32'h0);
    @(negedge clk);
    check_out("R2 back-to-back second", 2'd0, 32'h2000_0200, 32'h0);

    // R3: invalidate a descriptor
    wr_desc(4'd4, 32'h4000_0000, 28'h100, 3'b001, 0, 1);
    xlate("R3 invalidated", 32'h4000_0004, 2'd0, 2'd1, 32'h0);

    // Random mixed traffic, checked by the model every clock
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      req_valid = ($urandom_range(0, 3) != 0);
      req_type  = 2'($urandom_range(0, 3));
      req_addr  = {4'($urandom_range(0, 15)), 28'($urandom_range(0, 3) == 0 ?
                   $urandom_range(0, 'h0FF_FFFF) : $urandom_range('h7F00, 'h8100))};
      cfg_we    = ($urandom_range(0, 15) == 0);
      cfg_priv  = ($urandom_range(0, 3) != 0);
      cfg_idx   = 4'($urandom_range(0, 15));
      cfg_base  = $urandom;
      cfg_bound = 28'($urandom_range('h7F80, 'h8080));
      cfg_perm  = 3'($urandom_range(0, 7));
      cfg_valid = ($urandom_range(0, 4) != 0);
    end
    @(negedge clk);
    req_valid = 0; cfg_we = 0;
    repeat (4) @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule